// File: doc/BRIEF.md
# Crypto Engine Command Queue Interpreter

This block sits between a host and the control side of a block-cipher engine. The host pushes 32-bit command words into a small input FIFO. A sequencer takes them out one at a time. It decodes the opcode held in the top six bits and drives three controllers: a cipher datapath controller, a memory-transfer controller that moves words between external memory and the engine's internal RAM, and a key/crypto table loader. Two opcodes need a second word that holds an address. The sequencer collects that word from the queue before it acts.

Live status outputs show whether the queue is empty, whether the cipher is running and whether a memory transfer is in flight. A sticky status vector records errors and completions. Software clears a bit by writing a one to it. An interrupt is raised while any sticky bit is set that the enable mask selects. An enable value of 0x33 selects every source the block defines: opcode error (bit 0), overflow (bit 1), DMA complete (bit 4) and transfer done (bit 5). Firmware writes its commands and then waits for the interrupt or polls the busy outputs.

Top module: `xq_cmd_engine`

## Requirements
- R1: After a synchronous reset the queue is empty (`q_empty`=1), `eng_busy`, `dma_busy`, `ciph_req`, `mx_req`, `tbl_load` and `irq` are 0, and `status` is 0.
- R2: The queue holds up to DEPTH (default 5) words and hands them out in write order. At most one word is consumed per cycle. `q_empty` is 1 exactly when no word is held.
- R3: A write while the queue holds DEPTH words is dropped and sets status bit 1. This holds even if a word leaves in the same cycle.
- R4: The opcode is bits 31:26. Opcode 0x0E issues a one-cycle `ciph_req` with `ciph_nblk` = bits[NBLK_W-1:0] + 1, so a field of 0 means one 16-byte block.
- R5: Opcode 0x10 consumes the next queue word as the source address and presents it on `ciph_src`. It issues no request.
- R6: `eng_busy` is 1 from the cycle `ciph_req` is issued until the cycle after `ciph_done` is seen. No queue word is consumed while it is 1.
- R7: Opcode 0x22 takes its direction from bit 25 (0 = external memory to internal RAM, 1 = the reverse) and its word count from bits[12+MXW_W-1:12]. The next word is the address. `mx_req` pulses once that address has been taken. `dma_busy` stays 1 until `mx_done`, and `mx_done` sets status bit 5.
- R8: Opcode 0x15 gives a one-cycle `tbl_load` with `tbl_sel` = bits 25:24, `tbl_ram` = bit 23 and `tbl_slot` = bits 19:17 (the key-table id in bits 20:17 is 0x8 OR slot).
- R9: Opcode 0x11 sets status bit 4 when it is consumed.
- R10: Any other opcode sets status bit 0 and is discarded. The next word is decoded in the following cycle.
- R11: Writing ones to `stat_clr_mask` with `stat_clr_we` clears those status bits. An event that sets a bit in the same cycle wins over the clear.
- R12: `irq` is the OR of `status` AND `irq_en`, and it updates in the same cycle as `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command or address word |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 8 | Ones clear the matching status bits |
| irq_en | input | 8 | Interrupt enable mask |
| status | output | 8 | Sticky status: 0 opcode error, 1 overflow, 4 DMA complete, 5 transfer done |
| irq | output | 1 | Interrupt |
| q_empty | output | 1 | Command queue empty |
| eng_busy | output | 1 | Cipher running |
| dma_busy | output | 1 | Memory transfer in flight |
| ciph_req | output | 1 | Cipher start pulse |
| ciph_nblk | output | NBLK_W+1 | Block count for the cipher |
| ciph_src | output | 32 | Cipher source address |
| ciph_done | input | 1 | Cipher finished last block |
| mx_req | output | 1 | Memory transfer start pulse |
| mx_dir | output | 1 | Transfer direction |
| mx_words | output | MXW_W | Transfer word count |
| mx_addr | output | 32 | Transfer external address |
| mx_done | input | 1 | Memory transfer finished |
| tbl_load | output | 1 | Table load pulse |
| tbl_sel | output | 2 | Table select |
| tbl_ram | output | 1 | RAM select |
| tbl_slot | output | 3 | Key slot number |

## Verification
Event recording and the software clear meet on the same status register. The bench writes a DMA-complete command while the matching bit is already set. In the very cycle that command is decoded, it asserts a clear of that bit, and it expects the bit to stay set (the event wins). The same clash shows up at the queue: a write arriving on a full queue in the cycle a word leaves must still be dropped. A long cipher latency keeps the queue full so this can happen. Randomised clears and writes repeat both clashes many times, and a behavioural model checks them every clock.

// File: rtl/xq_pkg.sv
package xq_pkg;
  localparam int OPC_LSB = 26;
  localparam int OPC_W   = 6;
  localparam logic [OPC_W-1:0] OP_START = 6'h0E;
  localparam logic [OPC_W-1:0] OP_SETUP = 6'h10;
  localparam logic [OPC_W-1:0] OP_FIN   = 6'h11;
  localparam logic [OPC_W-1:0] OP_TABLE = 6'h15;
  localparam logic [OPC_W-1:0] OP_MOVE  = 6'h22;

  localparam int MX_DIR_BIT = 25;
  localparam int MX_CNT_LSB = 12;
  localparam int TB_SEL_LSB = 24;
  localparam int TB_RAM_BIT = 23;
  localparam int TB_SLT_LSB = 17;

  localparam int STAT_W     = 8;
  localparam int SB_OPC_ERR = 0;
  localparam int SB_OVF     = 1;
  localparam int SB_FIN     = 4;
  localparam int SB_MOVED   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARG  = 2'd1,
    ST_CIPH = 2'd2,
    ST_MOVE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/xq_fifo.sv
module xq_fifo #(
  parameter int DEPTH = 5,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_en,
  input  logic [W-1:0] push_data,
  input  logic         pop_en,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_d;
  logic          accept;

  assign full   = (cnt == CW'(DEPTH));
  assign empty  = (cnt == '0);
  assign accept = push_en && !full;
  assign drop   = push_en && full;
  assign head   = mem[rp];

  always_comb begin
    cnt_d = cnt;
    case ({accept, pop_en})
      2'b10:   cnt_d = cnt + 1'b1;
      2'b01:   cnt_d = cnt - 1'b1;
      default: cnt_d = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_en) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt_d;
    end
  end

  // R2
  pop_guard_chk: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> !empty);
endmodule

// File: rtl/xq_seq.sv
module xq_seq
  import xq_pkg::*;
#(
  parameter int NBLK_W = 12,
  parameter int MXW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              avail,
  input  logic [31:0]       head,
  input  logic              ciph_done,
  input  logic              mx_done,
  output logic              pop,
  output logic              ev_opc_err,
  output logic              ev_fin,
  output logic              ev_moved,
  output logic              ciph_req,
  output logic [NBLK_W:0]   ciph_nblk,
  output logic [31:0]       ciph_src,
  output logic              mx_req,
  output logic              mx_dir,
  output logic [MXW_W-1:0]  mx_words,
  output logic [31:0]       mx_addr,
  output logic              tbl_load,
  output logic [1:0]        tbl_sel,
  output logic              tbl_ram,
  output logic [2:0]        tbl_slot,
  output logic              eng_busy,
  output logic              dma_busy
);
  seq_st_e          st;
  logic             arg_is_move;
  logic [OPC_W-1:0] opc;
  logic             known;

  assign opc = head[OPC_LSB +: OPC_W];

  always_comb begin
    case (opc)
      OP_START, OP_SETUP, OP_FIN, OP_TABLE, OP_MOVE: known = 1'b1;
      default:                                       known = 1'b0;
    endcase
  end

  assign pop        = avail && (st == ST_IDLE || st == ST_ARG);
  assign ev_opc_err = avail && (st == ST_IDLE) && !known;
  assign ev_fin     = avail && (st == ST_IDLE) && (opc == OP_FIN);
  assign ev_moved   = (st == ST_MOVE) && mx_done;
  assign eng_busy   = (st == ST_CIPH);
  assign dma_busy   = (st == ST_MOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      arg_is_move <= 1'b0;
      ciph_req    <= 1'b0;
      ciph_nblk   <= '0;
      ciph_src    <= '0;
      mx_req      <= 1'b0;
      mx_dir      <= 1'b0;
      mx_words    <= '0;
      mx_addr     <= '0;
      tbl_load    <= 1'b0;
      tbl_sel     <= '0;
      tbl_ram     <= 1'b0;
      tbl_slot    <= '0;
    end else begin
      ciph_req <= 1'b0;
      mx_req   <= 1'b0;
      tbl_load <= 1'b0;
      case (st)
        ST_IDLE: if (avail) begin
          case (opc)
            OP_START: begin
              ciph_nblk <= {1'b0, head[NBLK_W-1:0]} + 1'b1;
              ciph_req  <= 1'b1;
              st        <= ST_CIPH;
            end
            OP_SETUP: begin
              arg_is_move <= 1'b0;
              st          <= ST_ARG;
            end
            OP_MOVE: begin
              arg_is_move <= 1'b1;
              mx_dir      <= head[MX_DIR_BIT];
              mx_words    <= head[MX_CNT_LSB +: MXW_W];
              st          <= ST_ARG;
            end
            OP_TABLE: begin
              tbl_load <= 1'b1;
              tbl_sel  <= head[TB_SEL_LSB +: 2];
              tbl_ram  <= head[TB_RAM_BIT];
              tbl_slot <= head[TB_SLT_LSB +: 3];
            end
            default: ;
          endcase
        end
        ST_ARG: if (avail) begin
          if (arg_is_move) begin
            mx_addr <= head;
            mx_req  <= 1'b1;
            st      <= ST_MOVE;
          end else begin
            ciph_src <= head;
            st       <= ST_IDLE;
          end
        end
        ST_CIPH: if (ciph_done) st <= ST_IDLE;
        ST_MOVE: if (mx_done)   st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  ciph_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ciph_req |=> !ciph_req);
  // R6
  ciph_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ciph_req |-> eng_busy);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_busy && !ciph_done) |=> eng_busy);
  // R7
  move_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mx_req |-> dma_busy);
endmodule

// File: rtl/xq_stat.sv
module xq_stat #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] ev,
  input  logic          clr_we,
  input  logic [SW-1:0] clr_mask,
  input  logic [SW-1:0] irq_en,
  output logic [SW-1:0] status,
  output logic          irq
);
  logic [SW-1:0] status_d;

  assign status_d = (status & ~(clr_we ? clr_mask : '0)) | ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |(status_d & irq_en);
    end
  end

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((status & $past(ev)) == $past(ev)));
  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(status & $past(irq_en))));
endmodule

// File: rtl/xq_cmd_engine.sv
module xq_cmd_engine
  import xq_pkg::*;
#(
  parameter int DEPTH  = 5,
  parameter int NBLK_W = 12,
  parameter int MXW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [31:0]       cmd_wdata,
  input  logic              stat_clr_we,
  input  logic [7:0]        stat_clr_mask,
  input  logic [7:0]        irq_en,
  output logic [7:0]        status,
  output logic              irq,
  output logic              q_empty,
  output logic              eng_busy,
  output logic              dma_busy,
  output logic              ciph_req,
  output logic [NBLK_W:0]   ciph_nblk,
  output logic [31:0]       ciph_src,
  input  logic              ciph_done,
  output logic              mx_req,
  output logic              mx_dir,
  output logic [MXW_W-1:0]  mx_words,
  output logic [31:0]       mx_addr,
  input  logic              mx_done,
  output logic              tbl_load,
  output logic [1:0]        tbl_sel,
  output logic              tbl_ram,
  output logic [2:0]        tbl_slot
);
  logic [31:0]       head;
  logic              q_full, q_drop, pop;
  logic              ev_opc_err, ev_fin, ev_moved;
  logic [STAT_W-1:0] ev;

  xq_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst(rst),
    .push_en(cmd_we), .push_data(cmd_wdata),
    .pop_en(pop), .head(head),
    .empty(q_empty), .full(q_full), .drop(q_drop)
  );

  xq_seq #(.NBLK_W(NBLK_W), .MXW_W(MXW_W)) u_seq (
    .clk(clk), .rst(rst),
    .avail(!q_empty), .head(head),
    .ciph_done(ciph_done), .mx_done(mx_done),
    .pop(pop),
    .ev_opc_err(ev_opc_err), .ev_fin(ev_fin), .ev_moved(ev_moved),
    .ciph_req(ciph_req), .ciph_nblk(ciph_nblk), .ciph_src(ciph_src),
    .mx_req(mx_req), .mx_dir(mx_dir), .mx_words(mx_words), .mx_addr(mx_addr),
    .tbl_load(tbl_load), .tbl_sel(tbl_sel), .tbl_ram(tbl_ram), .tbl_slot(tbl_slot),
    .eng_busy(eng_busy), .dma_busy(dma_busy)
  );

  always_comb begin
    ev             = '0;
    ev[SB_OPC_ERR] = ev_opc_err;
    ev[SB_OVF]     = q_drop;
    ev[SB_FIN]     = ev_fin;
    ev[SB_MOVED]   = ev_moved;
  end

  xq_stat #(.SW(STAT_W)) u_stat (
    .clk(clk), .rst(rst),
    .ev(ev), .clr_we(stat_clr_we), .clr_mask(stat_clr_mask),
    .irq_en(irq_en), .status(status), .irq(irq)
  );

  // R3
  drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && q_full) |=> status[SB_OVF]);
endmodule

// File: tb/xq_cmd_engine_test.sv
module xq_cmd_engine_test;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 5;
  localparam int NBLK_W = 12;
  localparam int MXW_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_we = 1'b0;
  logic [31:0]       cmd_wdata = '0;
  logic              stat_clr_we = 1'b0;
  logic [7:0]        stat_clr_mask = '0;
  logic [7:0]        irq_en = 8'h33;
  logic [7:0]        status;
  logic              irq, q_empty, eng_busy, dma_busy;
  logic              ciph_req;
  logic [NBLK_W:0]   ciph_nblk;
  logic [31:0]       ciph_src;
  logic              ciph_done = 1'b0;
  logic              mx_req, mx_dir;
  logic [MXW_W-1:0]  mx_words;
  logic [31:0]       mx_addr;
  logic              mx_done = 1'b0;
  logic              tbl_load, tbl_ram;
  logic [1:0]        tbl_sel;
  logic [2:0]        tbl_slot;

  int vectors = 0;
  int errors  = 0;
  int lat_force = 0;
  int ccnt = 0;
  int mcnt = 0;
  bit armed = 0;
  bit done_flag = 0;

  xq_cmd_engine #(.DEPTH(DEPTH), .NBLK_W(NBLK_W), .MXW_W(MXW_W)) uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask), .irq_en(irq_en),
    .status(status), .irq(irq), .q_empty(q_empty), .eng_busy(eng_busy),
    .dma_busy(dma_busy), .ciph_req(ciph_req), .ciph_nblk(ciph_nblk),
    .ciph_src(ciph_src), .ciph_done(ciph_done), .mx_req(mx_req), .mx_dir(mx_dir),
    .mx_words(mx_words), .mx_addr(mx_addr), .mx_done(mx_done),
    .tbl_load(tbl_load), .tbl_sel(tbl_sel), .tbl_ram(tbl_ram), .tbl_slot(tbl_slot)
  );

  always #(CLK_P/2) clk = ~clk;

  // stub controllers: answer each request after a latency
  always @(posedge clk) begin
    #1;
    ciph_done = 1'b0;
    mx_done   = 1'b0;
    if (rst) begin
      ccnt = 0; mcnt = 0;
    end else begin
      if (ciph_req) ccnt = (lat_force > 0) ? lat_force : $urandom_range(1, 6);
      else if (ccnt > 0) begin ccnt--; if (ccnt == 0) ciph_done = 1'b1; end
      if (mx_req) mcnt = (lat_force > 0) ? lat_force : $urandom_range(1, 6);
      else if (mcnt > 0) begin mcnt--; if (mcnt == 0) mx_done = 1'b1; end
    end
  end

  // reference model state
  bit [31:0]       mq[$];
  int              ms = 0;      // 0 idle, 1 address word, 2 cipher, 3 transfer
  bit              m_arg_move = 0;
  bit [7:0]        e_status = 0;
  bit              e_irq = 0, e_creq = 0, e_mreq = 0, e_tld = 0;
  bit [NBLK_W:0]   e_nblk = 0;
  bit [31:0]       e_src = 0, e_maddr = 0;
  bit              e_mdir = 0, e_tram = 0;
  bit [MXW_W-1:0]  e_mwords = 0;
  bit [1:0]        e_tsel = 0;
  bit [2:0]        e_tslot = 0;

  task automatic chk(input string tag, input string nm, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit [31:0] h;
    bit [7:0]  ev;
    bit        full, popq;
    bit [7:0]  st;
    if (rst) begin
      mq.delete(); ms = 0; m_arg_move = 0; e_status = 0; e_irq = 0;
      e_creq = 0; e_mreq = 0; e_tld = 0; e_nblk = 0; e_src = 0; e_maddr = 0;
      e_mdir = 0; e_tram = 0; e_mwords = 0; e_tsel = 0; e_tslot = 0;
      return;
    end
    ev = 0; popq = 0;
    full = (mq.size() == DEPTH);
    e_creq = 0; e_mreq = 0; e_tld = 0;
    case (ms)
      0: if (mq.size() > 0) begin
        h = mq[0]; popq = 1;
        case (h[31:26])
          6'h0E: begin e_nblk = {1'b0, h[NBLK_W-1:0]} + 1; e_creq = 1; ms = 2; end
          6'h10: begin m_arg_move = 0; ms = 1; end
          6'h22: begin m_arg_move = 1; e_mdir = h[25]; e_mwords = h[12 +: MXW_W]; ms = 1; end
          6'h15: begin e_tld = 1; e_tsel = h[25:24]; e_tram = h[23]; e_tslot = h[19:17]; end
          6'h11: ev[4] = 1;
          default: ev[0] = 1;
        endcase
      end
      1: if (mq.size() > 0) begin
        h = mq[0]; popq = 1;
        if (m_arg_move) begin e_maddr = h; e_mreq = 1; ms = 3; end
        else begin e_src = h; ms = 0; end
      end
      2: if (ciph_done) ms = 0;
      default: if (mx_done) begin ms = 0; ev[5] = 1; end
    endcase
    if (cmd_we && full) ev[1] = 1;
    if (popq) void'(mq.pop_front());
    if (cmd_we && !full) mq.push_back(cmd_wdata);
    st = (e_status & ~(stat_clr_we ? stat_clr_mask : 8'h00)) | ev;
    e_status = st;
    e_irq = |(st & irq_en);
  endtask

  // compare every clock, then advance the model with the inputs of this cycle
  always @(negedge clk) begin
    if (armed && !rst && !done_flag) begin
      chk("R2",  "q_empty",   q_empty,   mq.size() == 0);
      chk("R6",  "eng_busy",  eng_busy,  ms == 2);
      chk("R7",  "dma_busy",  dma_busy,  ms == 3);
      chk("R4",  "ciph_req",  ciph_req,  e_creq);
      chk("R4",  "ciph_nblk", ciph_nblk, e_nblk);
      chk("R5",  "ciph_src",  ciph_src,  e_src);
      chk("R7",  "mx_req",    mx_req,    e_mreq);
      chk("R7",  "mx_fields", {mx_dir, mx_words, mx_addr}, {e_mdir, e_mwords, e_maddr});
      chk("R8",  "tbl",       {tbl_load, tbl_sel, tbl_ram, tbl_slot},
                              {e_tld, e_tsel, e_tram, e_tslot});
      chk("R10", "status0",   status[0], e_status[0]);
      chk("R3",  "status1",   status[1], e_status[1]);
      chk("R9",  "status4",   status[4], e_status[4]);
      chk("R7",  "status5",   status[5], e_status[5]);
      chk("R11", "status_rest", {status[7:6], status[3:2]}, {e_status[7:6], e_status[3:2]});
      chk("R12", "irq",       irq,       e_irq);
    end
    model_step();
    if (rst) armed = 1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] w);
    cmd_we = 1'b1; cmd_wdata = w;
    tick();
    cmd_we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 200; i++) begin
      if (q_empty && !eng_busy && !dma_busy) break;
      tick();
    end
    tick();
  endtask

  function automatic logic [31:0] op(input logic [5:0] o, input logic [25:0] f);
    return {o, f};
  endfunction

  function automatic logic [31:0] rnd_word();
    case ($urandom_range(0, 6))
      0: return op(6'h0E, 26'($urandom_range(0, 7)));
      1: return op(6'h10, 26'($urandom));
      2: return op(6'h11, 26'h0);
      3: return op(6'h15, 26'($urandom));
      4: return op(6'h22, 26'($urandom));
      5: return op(6'h3F, 26'($urandom));
      default: return $urandom;
    endcase
  endfunction

  task automatic finish_run();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1", "reset_outs", {q_empty, eng_busy, dma_busy, ciph_req, mx_req, tbl_load, irq, status},
        {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});

    // R5 R4: address setup then a 4-block start
    wr(op(6'h10, 26'h0)); wr(32'h8000_1230); wr(op(6'h0E, 26'd3));
    settle();
    chk("R5", "src_addr", ciph_src, 32'h8000_1230);
    chk("R4", "nblk", ciph_nblk, 13'd4);
    wr(op(6'h0E, 26'd0));
    settle();
    chk("R4", "nblk_one", ciph_nblk, 13'd1);

    // R7 transfer, internal RAM to external, 16 words
    wr(op(6'h22, (26'd1 << 25) | (26'd16 << 12))); wr(32'h4000_0040);
    settle();
    chk("R7", "mx_dir_words", {mx_dir, mx_words}, {1'b1, 8'd16});
    chk("R7", "moved_flag", status[5], 1'b1);

    // R8 crypto table, RAM select, key slot 5
    wr(op(6'h15, (26'd3 << 24) | (26'd1 << 23) | (26'(8 | 5) << 17)));
    settle();
    chk("R8", "tbl_fields", {tbl_sel, tbl_ram, tbl_slot}, {2'd3, 1'b1, 3'd5});

    // R10 then R9: bad opcode back to back with completion
    wr(op(6'h3F, 26'h0)); wr(op(6'h11, 26'h0));
    settle();
    chk("R10", "opc_err", status[0], 1'b1);
    chk("R9", "fin_flag", status[4], 1'b1);
    chk("R12", "irq_on", irq, 1'b1);

    // R11 collision: clear bit 4 in the cycle a completion is decoded
    wr(op(6'h11, 26'h0));
    stat_clr_we = 1'b1; stat_clr_mask = 8'h10;
    tick();
    stat_clr_we = 1'b0;
    chk("R11", "set_wins", status[4], 1'b1);
    stat_clr_we = 1'b1; stat_clr_mask = 8'hFF;
    tick();
    stat_clr_we = 1'b0;
    chk("R11", "cleared", status, 8'h00);
    chk("R12", "irq_off", irq, 1'b0);

    // R3 overflow while the cipher holds the queue
    lat_force = 40;
    wr(op(6'h0E, 26'd7));
    tick();
    for (int i = 0; i < 7; i++) wr(op(6'h11, 26'h0));
    chk("R3", "ovf_flag", status[1], 1'b1);
    chk("R6", "busy_during", eng_busy, 1'b1);
    settle();
    lat_force = 0;
    stat_clr_we = 1'b1; stat_clr_mask = 8'hFF; tick(); stat_clr_we = 1'b0;

    // random mix, compared against the model every clock
    for (int n = 0; n < 4000; n++) begin
      cmd_we = ($urandom_range(0, 2) == 0);
      cmd_wdata = rnd_word();
      stat_clr_we = ($urandom_range(0, 7) == 0);
      stat_clr_mask = 8'($urandom);
      if ($urandom_range(0, 63) == 0) irq_en = 8'($urandom);
      if ($urandom_range(0, 99) == 0) lat_force = (lat_force == 0) ? 30 : 0;
      tick();
    end
    cmd_we = 1'b0; stat_clr_we = 1'b0; lat_force = 0;
    settle();
    finish_run();
  end
endmodule